// File: doc/BRIEF.md
# Prescaled Seconds Timer with Alarm

This block is a free-running up-counter meant for an always-on power domain. A slow input clock is divided by a programmable prescaler, and each division period produces one counter tick; with the prescaler set to the slow-clock frequency the counter counts seconds. Software cannot load the counter. It can only send it back to zero with a restart command carried in the mode register.

An alarm register is compared against the counter value that each tick produces. Two sticky status flags record an alarm match and a counter increment. Reading the status register clears both flags. Each flag has an interrupt enable placed exactly 16 bit positions above it in the mode register. The interrupt output is a registered level that stays high while any enabled flag is set.

The block sits on a simple single-cycle register bus with four word addresses. Address 0 is the mode register. Address 1 is the alarm register. Address 2 is the counter (read only). Address 3 is the status register (read only, cleared on read). Read data is combinational from the address, and the clear-on-read side effect happens only when the read strobe is high.

Top module: `tick_alarm_timer`

## Requirements
- R1: After reset the mode register reads the prescaler reset value with both enables at 0. The alarm reads all ones, the counter reads 0, the status reads 0 and the irq output is low.
- R2: The prescaler field is mode bits [PRE_W-1:0]. The counter advances by one once every N clock cycles, where N is that field, and a field of zero means N = 2^PRE_W.
- R3: Writes to the counter address (2) or the status address (3) change nothing that can be read back.
- R4: A mode write with bit 18 set returns the counter and the prescaler divider to zero. That same write also loads the prescaler field and the enables. Bit 18 always reads back as 0.
- R5: Status bit 1 (increment flag) is set on every counter increment.
- R6: Status bit 0 (alarm flag) is set on an increment whose new counter value equals the alarm register. This happens only when the alarm register is not all ones, which is the value that means disabled.
- R7: A strobed read of the status address returns the flags and then clears them. A flag event in the same cycle as the read wins, and that flag stays set.
- R8: One cycle after any status flag and its enable are both set, irq is high. The enables are mode bit 16 for the alarm flag and mode bit 17 for the increment flag. irq equals the registered OR of (status AND enables).
- R9: The counter wraps from its maximum value to zero and keeps counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock that drives the prescaler and the registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; a read of the status address clears the flags |
| addr | input | 2 | Word address: 0 mode, 1 alarm, 2 counter, 3 status |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the current address, zero-extended |
| irq | output | 1 | Registered interrupt level |

## Verification
The bench builds the block with an 8-bit counter, a 4-bit prescaler field and a prescaler reset value of 3. With these values the zero-means-maximum divide (16 cycles) and a full counter wrap both fit within a few hundred cycles. The 8-bit disabled alarm value, 0xFF, is also reached, so the check that it never fires is a real one. A behavioural model then predicts every status read, counter read and irq level, including reads that land on the same cycle as a tick.

// File: rtl/tat_pkg.sv
package tat_pkg;

  typedef enum logic [1:0] {
    A_MODE   = 2'd0,
    A_ALARM  = 2'd1,
    A_COUNT  = 2'd2,
    A_STATUS = 2'd3
  } reg_addr_e;

  localparam int FLAG_N    = 2;
  localparam int F_ALARM   = 0;
  localparam int F_INC     = 1;
  localparam int IE_SHIFT  = 16;
  localparam int RST_BIT   = 18;
  localparam int PRE_MAX_W = 16;

  // Division period for a prescaler field; zero selects 2^pre_w.
  function automatic logic [PRE_MAX_W:0] div_limit(
    input logic [PRE_MAX_W-1:0] pre,
    input int unsigned          pre_w
  );
    logic [PRE_MAX_W:0] r;
    if (pre == '0) r = {{PRE_MAX_W{1'b0}}, 1'b1} << pre_w;
    else           r = {1'b0, pre};
    return r;
  endfunction

  // True when an increment lands on an armed alarm value.
  function automatic logic alarm_match(
    input logic [63:0] next_cnt,
    input logic [63:0] alarm,
    input logic [63:0] off_val
  );
    return (next_cnt == alarm) && (alarm != off_val);
  endfunction

endpackage

// File: rtl/tat_prescaler.sv
module tat_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int PMW = tat_pkg::PRE_MAX_W;
  localparam int LW  = PMW + 1;

  logic [PRE_W-1:0] div_q;
  logic [PMW-1:0]   pre_ext;
  logic [LW-1:0]    limit;
  logic [LW-1:0]    div_next;

  always_comb begin
    pre_ext  = PMW'(pre);
    limit    = tat_pkg::div_limit(pre_ext, PRE_W);
    div_next = LW'(div_q) + LW'(1);
    tick     = !restart && (div_next >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (restart || tick)  div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tat_counter.sv
module tat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] alarm,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  localparam logic [CNT_W-1:0] OFF_VAL = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    hit     = tick && tat_pkg::alarm_match(64'(cnt_inc), 64'(alarm), 64'(OFF_VAL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_inc;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tat_status.sv
module tat_status #(
  parameter int FLAG_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] ev,
  input  logic              clr,
  input  logic [FLAG_N-1:0] ie,
  output logic [FLAG_N-1:0] stat,
  output logic              irq
);
  logic [FLAG_N-1:0] stat_q;
  logic              irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else begin
      for (int i = 0; i < FLAG_N; i++) begin
        if (ev[i])    stat_q[i] <= 1'b1;
        else if (clr) stat_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(stat_q & ie);
  end

  assign stat = stat_q;
  assign irq  = irq_q;
endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer #(
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 16,
  parameter int PRE_RST = 32768,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import tat_pkg::*;

  localparam int NF = tat_pkg::FLAG_N;

  logic [PRE_W-1:0] pre_q;
  logic [NF-1:0]    ie_q;
  logic [CNT_W-1:0] alarm_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NF-1:0]    stat_q;
  logic [NF-1:0]    ev_w;

  logic wr_mode_w;
  logic wr_alarm_w;
  logic rst_cmd_w;
  logic rd_clr_w;
  logic tick_w;
  logic alarm_hit_w;
  logic wdata_unused;

  assign wr_mode_w    = wr_en && (addr == A_MODE);
  assign wr_alarm_w   = wr_en && (addr == A_ALARM);
  assign rst_cmd_w    = wr_mode_w && wdata[RST_BIT];
  assign rd_clr_w     = rd_en && (addr == A_STATUS);
  assign wdata_unused = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= PRE_W'(PRE_RST);
      ie_q  <= '0;
    end else if (wr_mode_w) begin
      pre_q <= wdata[PRE_W-1:0];
      ie_q  <= wdata[IE_SHIFT +: NF];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          alarm_q <= '1;
    else if (wr_alarm_w) alarm_q <= wdata[CNT_W-1:0];
  end

  tat_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (rst_cmd_w),
    .pre     (pre_q),
    .tick    (tick_w)
  );

  tat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (rst_cmd_w),
    .tick    (tick_w),
    .alarm   (alarm_q),
    .cnt     (cnt_q),
    .hit     (alarm_hit_w)
  );

  always_comb begin
    ev_w          = '0;
    ev_w[F_ALARM] = alarm_hit_w;
    ev_w[F_INC]   = tick_w;
  end

  tat_status #(.FLAG_N(NF)) u_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (ev_w),
    .clr   (rd_clr_w),
    .ie    (ie_q),
    .stat  (stat_q),
    .irq   (irq)
  );

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_MODE: begin
        rdata[PRE_W-1:0]     = pre_q;
        rdata[IE_SHIFT +: NF] = ie_q;
      end
      A_ALARM:  rdata = DATA_W'(alarm_q);
      A_COUNT:  rdata = DATA_W'(cnt_q);
      default:  rdata = DATA_W'(stat_q);
    endcase
  end
endmodule

// File: rtl/tick_alarm_timer_chk.sv
module tick_alarm_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_w,
  input logic              rst_cmd_w,
  input logic              rd_clr_w,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  alarm_q,
  input logic [1:0]        stat_q,
  input logic [1:0]        ie_q,
  input logic              irq,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] rdata
);
  localparam logic [CNT_W-1:0] OFF_VAL = '1;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_w |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_w && !rst_cmd_w) |=> $stable(cnt_q));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cmd_w |=> (cnt_q == '0));

  p_rstbit_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> !rdata[18]);

  p_inc_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_w |=> stat_q[1]);

  p_alarm_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[0]) |-> ($past(tick_w) && ($past(alarm_q) != OFF_VAL)
                          && (cnt_q == $past(alarm_q))));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_w && !tick_w) |=> !stat_q[1]);

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(stat_q & ie_q))));
endmodule

bind tick_alarm_timer tick_alarm_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_w    (tick_w),
  .rst_cmd_w (rst_cmd_w),
  .rd_clr_w  (rd_clr_w),
  .cnt_q     (cnt_q),
  .alarm_q   (alarm_q),
  .stat_q    (stat_q),
  .ie_q      (ie_q),
  .irq       (irq),
  .addr      (addr),
  .rdata     (rdata)
);

// File: tb/test_tick_alarm_timer.sv
module test_tick_alarm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W   = 8;
  localparam int PRE_W   = 4;
  localparam int PRE_RST = 3;
  localparam int DATA_W  = 32;
  localparam int MAXC    = (1 << CNT_W) - 1;
  localparam int DIV_MAX = 1 << PRE_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int m_pre, m_alarm, m_cnt, m_div;
  bit m_aie, m_iie, m_af, m_if, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_alarm_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST), .DATA_W(DATA_W))
    i_tick_alarm_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input int a);
    case (a)
      0: return 32'(m_pre) | (32'(m_aie) << 16) | (32'(m_iie) << 17);
      1: return 32'(m_alarm);
      2: return 32'(m_cnt);
      default: return 32'(m_af) | (32'(m_if) << 1);
    endcase
  endfunction

  task automatic model_step(input bit wr, input bit rd, input int a, input logic [31:0] wd);
    int  lim;
    int  ncnt;
    bit  rstc, tk, aev, clr, nirq;
    lim  = (m_pre == 0) ? DIV_MAX : m_pre;
    rstc = wr && (a == 0) && wd[18];
    tk   = !rstc && (m_div + 1 >= lim);
    nirq = (m_af && m_aie) || (m_if && m_iie);
    ncnt = rstc ? 0 : (tk ? (m_cnt + 1) % (MAXC + 1) : m_cnt);
    aev  = tk && (ncnt == m_alarm) && (m_alarm != MAXC);
    clr  = rd && (a == 3);
    m_div = (rstc || tk) ? 0 : m_div + 1;
    m_if  = tk  ? 1'b1 : (clr ? 1'b0 : m_if);
    m_af  = aev ? 1'b1 : (clr ? 1'b0 : m_af);
    m_cnt = ncnt;
    m_irq = nirq;
    if (wr && a == 0) begin
      m_pre = int'(wd[PRE_W-1:0]);
      m_aie = wd[16];
      m_iie = wd[17];
    end
    if (wr && a == 1) m_alarm = int'(wd[CNT_W-1:0]);
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic cyc(input bit wr, input bit rd, input int a, input logic [31:0] wd, input string tag);
    wr_en = wr; rd_en = rd; addr = 2'(a); wdata = wd;
    #1;
    if (rd) check(rdata, exp_rdata(a), tag);
    @(posedge clk);
    model_step(wr, rd, a, wd);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check({31'b0, irq}, {31'b0, m_irq}, "R8 irq");
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, "");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_pre = PRE_RST; m_alarm = MAXC; m_cnt = 0; m_div = 0;
    m_aie = 0; m_iie = 0; m_af = 0; m_if = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, read right after release
    check({31'b0, irq}, 32'd0, "R1 irq");
    cyc(0, 1, 0, 0, "R1 mode");
    cyc(0, 1, 1, 0, "R1 alarm");
    check(rdata, 32'(MAXC), "R1 alarm ones");
    cyc(0, 1, 3, 0, "R1 status");

    // R4: restart with new prescaler 5, enables off
    cyc(1, 0, 0, 32'(5) | (32'd1 << 18), "R4");
    idle(12);
    cyc(0, 1, 2, 0, "R2 count div5");
    cyc(0, 1, 0, 0, "R4 mode readback");

    // R3: writes to counter and status are ignored
    cyc(1, 0, 2, 32'h55, "R3");
    cyc(1, 0, 3, 32'h3, "R3");
    cyc(0, 1, 2, 0, "R3 count");
    cyc(0, 1, 3, 0, "R3 status");

    // R5: increment flag after idle
    idle(6);
    cyc(0, 1, 3, 0, "R5 status");

    // R6/R8: alarm at 4, prescaler 2, alarm interrupt enabled
    cyc(1, 0, 1, 32'd4, "R6");
    cyc(1, 0, 0, 32'd2 | (32'd1 << 16) | (32'd1 << 18), "R6");
    idle(10);
    cyc(0, 1, 3, 0, "R6 status");
    idle(2);
    cyc(0, 1, 2, 0, "R6 count");

    // R7: tick every cycle, reads collide with events
    cyc(1, 0, 0, 32'd1 | (32'd1 << 17) | (32'd1 << 18), "R7");
    idle(2);
    cyc(0, 1, 3, 0, "R7 first read");
    cyc(0, 1, 3, 0, "R7 collide read");
    cyc(1, 0, 0, 32'd4 | (32'd1 << 18), "R7");
    idle(5);
    cyc(0, 1, 3, 0, "R7 clear read");
    cyc(0, 1, 3, 0, "R7 after clear");

    // R2: prescaler zero means divide by 2^PRE_W
    cyc(1, 0, 0, 32'd1 << 18, "R2");
    idle(DIV_MAX + 4);
    cyc(0, 1, 2, 0, "R2 count div max");
    cyc(0, 1, 0, 0, "R2 mode zero");

    // R9/R6: wrap with disabled alarm, then wrap onto alarm 0
    cyc(1, 0, 1, 32'(MAXC), "R6");
    cyc(1, 0, 0, 32'd1 | (32'd1 << 16) | (32'd1 << 18), "R9");
    cyc(0, 1, 3, 0, "R9 clear");
    idle(MAXC + 40);
    cyc(0, 1, 2, 0, "R9 count wrapped");
    cyc(0, 1, 3, 0, "R6 disabled alarm");
    cyc(1, 0, 1, 32'd0, "R6");
    cyc(1, 0, 0, 32'd1 | (32'd1 << 16) | (32'd1 << 18), "R9");
    idle(MAXC + 3);
    cyc(0, 1, 3, 0, "R6 alarm at wrap");
    cyc(0, 1, 2, 0, "R9 count");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule